// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel of a general-purpose timer. Two raw pins feed it: the channel's own pin and the pin of the neighbouring channel. A third input is a trigger pulse from the timer's slave controller. Each pin passes through its own digital filter and edge detector. A polarity setting picks whether rising or falling edges count as events. A two-bit source select then chooses the own pin, the neighbour pin or the trigger, or it parks the channel in compare mode, where nothing is captured. A prescaler passes one event out of every 1, 2, 4 or 8. On each event it passes, the current value of the external 16-bit time-base counter is latched.

The captured value goes first into a shadow register and is then copied into a preload register that software reads one byte at a time. Reading the high byte opens a read window. While that window is open, the copy from shadow to preload is held back, so the two bytes always come from the same capture. A capture that lands inside the window raises an overcapture flag. The captured value is copied out once the low byte has been read. A capture flag tells software that a fresh value is waiting.

Top module: `tcap_channel`

## Requirements
- R1: The filtered level of each pin changes only after N consecutive clock samples differ from it. N equals the filter field plus one, and field values of 7 and above all give N = 8.
- R2: With polarity 0 a rising edge of the filtered pin is an event, and with polarity 1 a falling edge is. The opposite edge has no effect.
- R3: Source code 01 captures on the own pin's events and code 10 on the neighbour pin's events. Code 11 captures on each clock cycle where the trigger input is high. A source that is not selected has no effect.
- R4: With source code 00 no capture takes place from any input.
- R5: While the enable input is low no capture takes place.
- R6: Prescale code p (0..3) lets through every 2^p-th selected event. The event counter restarts from zero whenever enable is low or the prescale code changes.
- R7: A capture latches the counter value present in the clock cycle of the passed event. The next free cycle copies it to the read register. rd_data shows the high byte in a cycle where rd_hi is high and the low byte otherwise.
- R8: From the cycle rd_hi is asserted until the cycle after rd_lo, the read register does not change. A capture held back in this way is copied afterwards.
- R9: A capture while the read window is open sets ovr_flag. The next rd_hi clears it, and a new set wins over the clear.
- R10: cap_flag is set when a captured value reaches the read register and cleared by rd_lo. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_own | input | 1 | Raw pin of this channel |
| pin_nbr | input | 1 | Raw pin of the neighbouring channel |
| trig_in | input | 1 | Trigger pulse from the slave controller |
| cnt_val | input | 16 | Time-base counter value |
| cfg_filt | input | 4 | Filter length field |
| cfg_pol | input | 1 | Edge polarity: 0 rising, 1 falling |
| cfg_src | input | 2 | Capture source select |
| cfg_psc | input | 2 | Prescale code |
| cfg_en | input | 1 | Capture enable |
| rd_hi | input | 1 | High-byte read strobe |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_data | output | 8 | Byte of the read register |
| cap_flag | output | 1 | Fresh capture waiting |
| ovr_flag | output | 1 | Capture arrived during a read window |

## Verification
The bench sends pin pulses one cycle shorter than the filter length and exactly as long as it, including the saturated length of 8. A filter that is off by one accepts the glitch or misses the real edge. It interleaves captures with a split read and expects the low byte to come from the old value. A design that does not hold the copy would return a torn pair and would never raise overcapture. It also breaks prescaler counts by toggling enable and changing the prescale code part-way through. A counter that is not cleared then produces a capture flag several events too early.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  typedef enum logic [1:0] {
    SRC_OUT = 2'b00,
    SRC_OWN = 2'b01,
    SRC_NBR = 2'b10,
    SRC_TRG = 2'b11
  } src_e;

  localparam int FILT_W  = 4;
  localparam int PSC_W   = 2;
  localparam int PCNT_W  = 3;

  // samples needed before the filtered level follows the pin
  function automatic logic [FILT_W-1:0] filt_need(input logic [FILT_W-1:0] f);
    if (f >= 4'd7) return 4'd8;
    return f + 4'd1;
  endfunction

  // number of events per passed event
  function automatic logic [PCNT_W:0] psc_div(input logic [PSC_W-1:0] p);
    return 4'd1 << p;
  endfunction
endpackage

// File: rtl/tcap_filter.sv
module tcap_filter
  import tcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin,
  input  logic [FILT_W-1:0] cfg_filt,
  output logic              rise,
  output logic              fall
);
  logic              pin_q, lvl_q, lvl_d;
  logic [FILT_W-1:0] run_q;
  logic [FILT_W-1:0] run_nx;
  logic [FILT_W-1:0] need;

  assign need   = filt_need(cfg_filt);
  assign run_nx = run_q + 4'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      lvl_q <= 1'b0;
      lvl_d <= 1'b0;
      run_q <= '0;
    end else begin
      pin_q <= pin;
      lvl_d <= lvl_q;
      if (pin_q != lvl_q) begin
        if (run_nx >= need) begin
          lvl_q <= pin_q;
          run_q <= '0;
        end else begin
          run_q <= run_nx;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign rise = lvl_q & ~lvl_d;
  assign fall = ~lvl_q & lvl_d;
endmodule

// File: rtl/tcap_presc.sv
module tcap_presc
  import tcap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  input  logic             ev,
  output logic             fire
);
  logic [PSC_W-1:0]  psc_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic [PCNT_W-1:0] eff;
  logic [PCNT_W:0]   eff_inc;
  logic              clr;

  assign clr     = !en || (psc != psc_q);
  assign eff     = clr ? '0 : pcnt_q;
  assign eff_inc = {1'b0, eff} + 4'd1;
  assign fire    = ev && en && (eff_inc == psc_div(psc));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      pcnt_q <= '0;
    end else begin
      psc_q <= psc;
      if (ev && en) pcnt_q <= fire ? '0 : eff_inc[PCNT_W-1:0];
      else          pcnt_q <= eff;
    end
  end
endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
  import tcap_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_own,
  input  logic              pin_nbr,
  input  logic              trig_in,
  input  logic [CW-1:0]     cnt_val,
  input  logic [FILT_W-1:0] cfg_filt,
  input  logic              cfg_pol,
  input  logic [1:0]        cfg_src,
  input  logic [PSC_W-1:0]  cfg_psc,
  input  logic              cfg_en,
  input  logic              rd_hi,
  input  logic              rd_lo,
  output logic [CW/2-1:0]   rd_data,
  output logic              cap_flag,
  output logic              ovr_flag
);
  localparam int HW = CW / 2;
  localparam int NPIN = 2;

  logic [NPIN-1:0] pins, rise, fall, pol_ev;
  logic            sel_ev, en_cap, cap_evt, hold, xfer;
  logic            rip_q, pend_q, cflag_q, oflag_q;
  logic [CW-1:0]   shd_q, pre_q;

  assign pins = {pin_nbr, pin_own};

  for (genvar i = 0; i < NPIN; i++) begin : g_in
    tcap_filter u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (pins[i]),
      .cfg_filt (cfg_filt),
      .rise     (rise[i]),
      .fall     (fall[i])
    );
    assign pol_ev[i] = cfg_pol ? fall[i] : rise[i];
  end

  always_comb begin
    case (src_e'(cfg_src))
      SRC_OWN: sel_ev = pol_ev[0];
      SRC_NBR: sel_ev = pol_ev[1];
      SRC_TRG: sel_ev = trig_in;
      default: sel_ev = 1'b0;
    endcase
  end

  assign en_cap = cfg_en && (src_e'(cfg_src) != SRC_OUT);

  tcap_presc u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en_cap),
    .psc   (cfg_psc),
    .ev    (sel_ev),
    .fire  (cap_evt)
  );

  // copy is held from the high-byte strobe until the window closes
  assign hold = rip_q || rd_hi;
  assign xfer = pend_q && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q   <= '0;
      pre_q   <= '0;
      pend_q  <= 1'b0;
      rip_q   <= 1'b0;
      cflag_q <= 1'b0;
      oflag_q <= 1'b0;
    end else begin
      if (cap_evt) begin
        shd_q  <= cnt_val;
        pend_q <= 1'b1;
      end else if (xfer) begin
        pend_q <= 1'b0;
      end
      if (xfer) pre_q <= shd_q;

      if (rd_hi)      rip_q <= 1'b1;
      else if (rd_lo) rip_q <= 1'b0;

      if (xfer)       cflag_q <= 1'b1;
      else if (rd_lo) cflag_q <= 1'b0;

      if (cap_evt && rip_q) oflag_q <= 1'b1;
      else if (rd_hi)       oflag_q <= 1'b0;
    end
  end

  assign rd_data  = rd_hi ? pre_q[CW-1:HW] : pre_q[HW-1:0];
  assign cap_flag = cflag_q;
  assign ovr_flag = oflag_q;
endmodule

// File: rtl/tcap_checks.sv
module tcap_checks #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic [1:0]    cfg_src,
  input logic          rd_hi,
  input logic          rd_lo,
  input logic          rip,
  input logic          cap_evt,
  input logic [CW-1:0] pre,
  input logic [CW-1:0] shd,
  input logic          cap_flag,
  input logic          ovr_flag
);
  // R8: the read register stays put across the read window
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rip || rd_hi) |=> $stable(pre));

  // R9: a capture inside the window raises overcapture
  a_r9_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && rip) |=> ovr_flag);

  // R10: the low-byte read that closes the window clears the capture flag
  a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && rip) |=> !cap_flag);

  // R4 / R5: with the channel off or in compare mode the shadow never moves
  a_r5_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en || cfg_src == 2'b00) |=> $stable(shd));

  // R7: a capture without an open window reaches the read register next cycle
  a_r7_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !rip && !rd_hi) |=> ##1 (rip || $past(rd_hi) || pre == $past(shd)));
endmodule

bind tcap_channel tcap_checks #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_en   (cfg_en),
  .cfg_src  (cfg_src),
  .rd_hi    (rd_hi),
  .rd_lo    (rd_lo),
  .rip      (rip_q),
  .cap_evt  (cap_evt),
  .pre      (pre_q),
  .shd      (shd_q),
  .cap_flag (cap_flag),
  .ovr_flag (ovr_flag)
);

// File: tb/tb_tcap_channel.sv
module tb_tcap_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_own = 1'b0, pin_nbr = 1'b0, trig_in = 1'b0;
  logic [15:0] cnt_val = '0;
  logic [3:0]  cfg_filt = '0;
  logic        cfg_pol = 1'b0;
  logic [1:0]  cfg_src = 2'b01;
  logic [1:0]  cfg_psc = '0;
  logic        cfg_en = 1'b1;
  logic        rd_hi = 1'b0, rd_lo = 1'b0;
  logic [7:0]  rd_data;
  logic        cap_flag, ovr_flag;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tcap_channel dut (
    .clk(clk), .rst_n(rst_n), .pin_own(pin_own), .pin_nbr(pin_nbr),
    .trig_in(trig_in), .cnt_val(cnt_val), .cfg_filt(cfg_filt),
    .cfg_pol(cfg_pol), .cfg_src(cfg_src), .cfg_psc(cfg_psc),
    .cfg_en(cfg_en), .rd_hi(rd_hi), .rd_lo(rd_lo), .rd_data(rd_data),
    .cap_flag(cap_flag), .ovr_flag(ovr_flag)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_pin(input bit nbr, input int len);
    @(negedge clk);
    if (nbr) pin_nbr = 1'b1; else pin_own = 1'b1;
    step(len);
    if (nbr) pin_nbr = 1'b0; else pin_own = 1'b0;
    step(12);
  endtask

  task automatic trig();
    @(negedge clk); trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
    step(3);
  endtask

  task automatic read_hi(output logic [7:0] b);
    @(negedge clk); rd_hi = 1'b1; #2 b = rd_data;
    @(negedge clk); rd_hi = 1'b0;
  endtask

  task automatic read_lo(output logic [7:0] b);
    @(negedge clk); rd_lo = 1'b1; #2 b = rd_data;
    @(negedge clk); rd_lo = 1'b0;
  endtask

  task automatic read16(output logic [15:0] v);
    logic [7:0] h, l;
    read_hi(h);
    read_lo(l);
    v = {h, l};
  endtask

  task automatic t_reset();
    #2;
    chk("R10 reset cap_flag", {15'd0, cap_flag}, 16'd0);
    chk("R9 reset ovr_flag", {15'd0, ovr_flag}, 16'd0);
    chk("R7 reset rd_data", {8'd0, rd_data}, 16'd0);
  endtask

  task automatic t_filter();
    logic [15:0] v;
    cfg_filt = 4'd3; cnt_val = 16'h1234;
    pulse_pin(0, 3);
    chk("R1 glitch of 3 with N=4", {15'd0, cap_flag}, 16'd0);
    pulse_pin(0, 4);
    chk("R1 pulse of 4 with N=4", {15'd0, cap_flag}, 16'd1);
    cnt_val = 16'hFFFF;
    read16(v);
    chk("R7 captured value", v, 16'h1234);
    #2 chk("R10 cleared by low read", {15'd0, cap_flag}, 16'd0);
    cfg_filt = 4'd12; cnt_val = 16'h00C8;
    pulse_pin(0, 7);
    chk("R1 glitch of 7 with saturated N=8", {15'd0, cap_flag}, 16'd0);
    pulse_pin(0, 8);
    chk("R1 pulse of 8 with saturated N=8", {15'd0, cap_flag}, 16'd1);
    read16(v);
    chk("R1 value after saturated filter", v, 16'h00C8);
    cfg_filt = 4'd0;
  endtask

  task automatic t_polarity();
    logic [15:0] v;
    cfg_pol = 1'b1; cnt_val = 16'h0A0A;
    @(negedge clk); pin_own = 1'b1;
    step(8);
    chk("R2 rising edge ignored with polarity 1", {15'd0, cap_flag}, 16'd0);
    cnt_val = 16'h5B5B; pin_own = 1'b0;
    step(8);
    chk("R2 falling edge captures", {15'd0, cap_flag}, 16'd1);
    read16(v);
    chk("R2 value at falling edge", v, 16'h5B5B);
    cfg_pol = 1'b0;
  endtask

  task automatic t_source();
    logic [15:0] v;
    cfg_src = 2'b10; cnt_val = 16'h1111;
    pulse_pin(0, 2);
    chk("R3 own pin ignored with source 10", {15'd0, cap_flag}, 16'd0);
    cnt_val = 16'h3C3C;
    pulse_pin(1, 2);
    chk("R3 neighbour pin captures", {15'd0, cap_flag}, 16'd1);
    read16(v);
    chk("R3 neighbour value", v, 16'h3C3C);
    cfg_src = 2'b11; cnt_val = 16'h2222;
    pulse_pin(0, 2);
    chk("R3 own pin ignored with source 11", {15'd0, cap_flag}, 16'd0);
    cnt_val = 16'h7E01;
    trig();
    chk("R3 trigger captures", {15'd0, cap_flag}, 16'd1);
    read16(v);
    chk("R3 trigger value", v, 16'h7E01);
  endtask

  task automatic t_off();
    logic [15:0] v;
    cfg_src = 2'b00; cnt_val = 16'h9999;
    trig();
    pulse_pin(0, 2);
    pulse_pin(1, 2);
    chk("R4 no capture in compare mode", {15'd0, cap_flag}, 16'd0);
    read16(v);
    chk("R4 read register kept", v, 16'h7E01);
    cfg_src = 2'b11; cfg_en = 1'b0;
    trig();
    chk("R5 no capture when disabled", {15'd0, cap_flag}, 16'd0);
    read16(v);
    chk("R5 read register kept", v, 16'h7E01);
    cfg_en = 1'b1;
  endtask

  task automatic t_presc();
    logic [15:0] v;
    cfg_src = 2'b11; cfg_psc = 2'd2;
    step(2);
    for (int i = 1; i <= 3; i++) begin cnt_val = 16'h0100 + 16'(i); trig(); end
    chk("R6 three events at /4", {15'd0, cap_flag}, 16'd0);
    cnt_val = 16'h0404; trig();
    chk("R6 fourth event at /4", {15'd0, cap_flag}, 16'd1);
    read16(v);
    chk("R6 value at /4", v, 16'h0404);
    // prescale change part-way: 2 counted, then restart at /8
    for (int i = 0; i < 2; i++) trig();
    cfg_psc = 2'd3;
    step(2);
    for (int i = 0; i < 7; i++) trig();
    chk("R6 counter restarted by prescale change", {15'd0, cap_flag}, 16'd0);
    cnt_val = 16'h0808; trig();
    chk("R6 eighth event after change", {15'd0, cap_flag}, 16'd1);
    read16(v);
    chk("R6 value at /8", v, 16'h0808);
    // disable part-way
    for (int i = 0; i < 5; i++) trig();
    cfg_en = 1'b0; step(2); cfg_en = 1'b1; step(1);
    for (int i = 0; i < 7; i++) trig();
    chk("R6 counter restarted by disable", {15'd0, cap_flag}, 16'd0);
    cnt_val = 16'h0888; trig();
    chk("R6 eighth event after enable", {15'd0, cap_flag}, 16'd1);
    read16(v);
    chk("R6 value after enable", v, 16'h0888);
    cfg_psc = 2'd0;
    step(2);
  endtask

  task automatic t_coherent();
    logic [7:0]  h, l;
    logic [15:0] v;
    cfg_src = 2'b11; cnt_val = 16'hA1B2;
    trig();
    chk("R10 flag after capture", {15'd0, cap_flag}, 16'd1);
    read_hi(h);
    chk("R7 high byte", {8'd0, h}, 16'h00A1);
    cnt_val = 16'hC3D4;
    trig();
    chk("R9 overcapture inside window", {15'd0, ovr_flag}, 16'd1);
    read_lo(l);
    chk("R8 low byte from same capture", {8'd0, l}, 16'h00B2);
    step(3);
    chk("R10 held capture copied after window", {15'd0, cap_flag}, 16'd1);
    read_hi(h);
    #2 chk("R9 cleared by next high read", {15'd0, ovr_flag}, 16'd0);
    read_lo(l);
    chk("R8 held value delivered", {h, l}, 16'hC3D4);
    #2 chk("R10 cleared after read", {15'd0, cap_flag}, 16'd0);
    v = {h, l};
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_filter();
    t_polarity();
    t_source();
    t_off();
    t_presc();
    t_coherent();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule